// File: doc/BRIEF.md
# Serial Interrupt Bus Peripheral Agent

This block is the peripheral side of a serialized interrupt line shared on a wired, pulled-up bus clocked by the PCI clock. A few local interrupt or data inputs are each tied to a fixed frame slot of the serial cycle. The agent follows every cycle on the bus: it waits for a Start pulse to end, counts frames of three clocks each (sample, recovery, turnaround) and drives the line for its own slots. For an asserted input it pulls the line low in the slot's sample clock, drives it high in the recovery clock and releases it in the turnaround clock. A deasserted slot is never driven.

The agent also works out the bus mode from the low width of each Stop pulse. A width of two clocks selects Quiet mode and three clocks selects Continuous mode. In Quiet mode, when an input holds a value that no cycle has yet carried, and the bus is idle, the agent opens a cycle itself. It does this by pulling the line low for one clock and then releasing it. In Continuous mode, which is the mode after reset, it never opens a cycle and waits for the host instead.

The bus level is supplied on `bus_in`. The agent drives through `drv_en` and `drv_val`, and outside logic resolves these onto the open-drain line.

Top module: `sirq_agent`

## Requirements
- R1: After reset the agent does not drive the line (`drv_en` low) and assumes Continuous mode.
- R2: In Continuous mode the agent never opens a cycle, even while an input holds an undelivered value.
- R3: In Quiet mode, with the bus idle and an undelivered input value, the agent drives the line low (`drv_en`=1, `drv_val`=0) for exactly one clock and then releases it, never driving it high.
- R4: An input change made during a cycle before that input's slot is carried by that cycle, and it does not cause a new cycle afterwards.
- R5: An input change made during a cycle after that input's slot has passed causes a cycle to be opened after the Stop frame (Quiet mode).
- R6: Frame 0's sample clock is the first clock after the clock in which the line returns high at the end of the Start pulse. Frame f's sample clock follows 3·f clocks later.
- R7: For an asserted slot the line is driven low in the sample clock, high in the recovery clock, and released in the turnaround clock. A deasserted slot is left released for all three clocks.
- R8: Input i owns frame BASE_SLOT+i (frames 1..3 with the defaults). No other frame is ever driven.
- R9: A Stop pulse low for 2 clocks selects Quiet mode, 3 clocks selects Continuous mode, and any other width leaves the mode unchanged.
- R10: After the Stop pulse's high clock, the agent waits one turnaround clock and one idle clock before it may drive a new Start pulse.
- R11: A slot carries the input's level as it stood at the clock edge that opens the slot's sample clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Local interrupt/data levels, 1 = asserted |
| bus_in | input | 1 | Sensed level of the serial interrupt line |
| drv_en | output | 1 | Agent drives the line this clock |
| drv_val | output | 1 | Value driven while `drv_en` is high |

## Verification
The bench acts as the host. In both modes it sweeps all eight input patterns through complete cycles. This shows that each slot drives alone and at its own frame, and that idle frames stay quiet. It changes inputs before and after their slot inside a cycle, which separates a change that the running cycle absorbs from one that must open a new cycle. Stop widths of 2, 3 and 4 clocks are followed by an idle stretch with a pending change. Whether the agent starts a cycle then shows which mode it decoded.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START_DRV,
    ST_START_LOW,
    ST_FRAMES,
    ST_STOP_WAIT,
    ST_STOP_LOW,
    ST_STOP_TA
  } sirq_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE,
    PH_RECOVER,
    PH_TURN
  } sirq_phase_e;

  // Mode chosen by a Stop pulse of the given low width; other widths keep the old mode.
  function automatic logic next_quiet(input int unsigned width, input logic cur_quiet);
    if (width == 2)      return 1'b1;
    else if (width == 3) return 1'b0;
    else                 return cur_quiet;
  endfunction

  // Frame index owned by local input i.
  function automatic int unsigned slot_of(input int unsigned base, input int unsigned i);
    return base + i;
  endfunction

endpackage

// File: rtl/sirq_cycle_fsm.sv
module sirq_cycle_fsm
  import sirq_pkg::*;
#(
  parameter int NUM_FRAMES = 6,
  parameter int FW         = 3,
  parameter int SW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_in,
  input  logic          want_start,
  output sirq_state_e   st,
  output sirq_phase_e   phase,
  output logic [FW-1:0] frame_idx,
  output logic          enter_frame,
  output logic [FW-1:0] enter_idx,
  output logic          stop_end,
  output logic          quiet
);

  localparam logic [FW-1:0] LAST_FRAME = FW'(NUM_FRAMES - 1);
  localparam logic [SW-1:0] CNT_MAX    = '1;

  sirq_state_e   st_n;
  sirq_phase_e   ph_n;
  logic [FW-1:0] fr_n;
  logic [SW-1:0] stop_cnt;

  always_comb begin
    st_n        = st;
    ph_n        = phase;
    fr_n        = frame_idx;
    enter_frame = 1'b0;
    enter_idx   = '0;
    stop_end    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (!bus_in)                 st_n = ST_START_LOW;
        else if (quiet && want_start) st_n = ST_START_DRV;
      end
      ST_START_DRV: st_n = ST_START_LOW;
      ST_START_LOW: begin
        if (bus_in) begin
          st_n        = ST_FRAMES;
          fr_n        = '0;
          ph_n        = PH_SAMPLE;
          enter_frame = 1'b1;
          enter_idx   = '0;
        end
      end
      ST_FRAMES: begin
        case (phase)
          PH_SAMPLE:  ph_n = PH_RECOVER;
          PH_RECOVER: ph_n = PH_TURN;
          default: begin
            if (frame_idx == LAST_FRAME) begin
              st_n = ST_STOP_WAIT;
            end else begin
              fr_n        = frame_idx + 1'b1;
              ph_n        = PH_SAMPLE;
              enter_frame = 1'b1;
              enter_idx   = frame_idx + 1'b1;
            end
          end
        endcase
      end
      ST_STOP_WAIT: if (!bus_in) st_n = ST_STOP_LOW;
      ST_STOP_LOW: begin
        if (bus_in) begin
          st_n     = ST_STOP_TA;
          stop_end = 1'b1;
        end
      end
      ST_STOP_TA: st_n = ST_IDLE;
      default:    st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      phase     <= PH_SAMPLE;
      frame_idx <= '0;
    end else begin
      st        <= st_n;
      phase     <= ph_n;
      frame_idx <= fr_n;
    end
  end

  // Stop pulse low-width counter (saturating)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_cnt <= '0;
    end else if (st == ST_STOP_WAIT && !bus_in) begin
      stop_cnt <= SW'(1);
    end else if (st == ST_STOP_LOW && !bus_in && stop_cnt != CNT_MAX) begin
      stop_cnt <= stop_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quiet <= 1'b0;
    else if (stop_end) quiet <= next_quiet(32'(stop_cnt), quiet);
  end

endmodule

// File: rtl/sirq_slot_drive.sv
module sirq_slot_drive
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ   = 3,
  parameter int BASE_SLOT = 1,
  parameter int FW        = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               enter_frame,
  input  logic [FW-1:0]      enter_idx,
  output logic               cur_assert,
  output logic               change_pend
);

  logic [NUM_IRQ-1:0] sent;
  logic [NUM_IRQ-1:0] hit;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_hit
    assign hit[g] = enter_frame &&
                    (32'(enter_idx) == slot_of(BASE_SLOT, g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent       <= '0;
      cur_assert <= 1'b0;
    end else if (enter_frame) begin
      cur_assert <= |(hit & irq_in);
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (hit[i]) sent[i] <= irq_in[i];
      end
    end
  end

  assign change_pend = |(irq_in ^ sent);

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ    = 3,
  parameter int BASE_SLOT  = 1,
  parameter int NUM_FRAMES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_in,
  output logic               drv_en,
  output logic               drv_val
);

  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam int SW = 4;

  sirq_state_e   st;
  sirq_phase_e   phase;
  logic [FW-1:0] frame_idx;
  logic          enter_frame;
  logic [FW-1:0] enter_idx;
  logic          stop_end;
  logic          quiet;
  logic          cur_assert;
  logic          change_pend;

  // Named events for the checker
  logic start_drv;
  logic in_idle;
  logic in_frames;

  assign start_drv = (st == ST_START_DRV);
  assign in_idle   = (st == ST_IDLE);
  assign in_frames = (st == ST_FRAMES);

  sirq_cycle_fsm #(
    .NUM_FRAMES(NUM_FRAMES),
    .FW        (FW),
    .SW        (SW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_in     (bus_in),
    .want_start (change_pend),
    .st         (st),
    .phase      (phase),
    .frame_idx  (frame_idx),
    .enter_frame(enter_frame),
    .enter_idx  (enter_idx),
    .stop_end   (stop_end),
    .quiet      (quiet)
  );

  sirq_slot_drive #(
    .NUM_IRQ  (NUM_IRQ),
    .BASE_SLOT(BASE_SLOT),
    .FW       (FW)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .enter_frame(enter_frame),
    .enter_idx  (enter_idx),
    .cur_assert (cur_assert),
    .change_pend(change_pend)
  );

  assign drv_en  = start_drv | (in_frames && phase != PH_TURN && cur_assert);
  assign drv_val = in_frames && phase == PH_RECOVER;

endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk #(
  parameter int NUM_IRQ   = 3,
  parameter int BASE_SLOT = 1,
  parameter int FW        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_in,
  input logic          drv_en,
  input logic          drv_val,
  input logic          start_drv,
  input logic          in_idle,
  input logic          stop_end,
  input logic          quiet,
  input logic [FW-1:0] frame_idx
);

  // R2
  start_quiet_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_drv |-> quiet);

  // R3
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_drv |-> $past(in_idle && bus_in));

  // R3
  start_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_drv |=> !drv_en);

  // R7
  high_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_val) |-> $past(drv_en && !drv_val));

  // R7
  slot_low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !drv_val && !start_drv) |=> (drv_en && drv_val));

  // R8
  own_frames_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !start_drv) |->
      (32'(frame_idx) >= BASE_SLOT && 32'(frame_idx) < BASE_SLOT + NUM_IRQ));

  // R9
  mode_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quiet) |-> $past(stop_end));

  // R10
  turnaround_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_end |=> !drv_en);

endmodule

bind sirq_agent sirq_agent_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .BASE_SLOT(BASE_SLOT),
  .FW       (FW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_in   (bus_in),
  .drv_en   (drv_en),
  .drv_val  (drv_val),
  .start_drv(start_drv),
  .in_idle  (in_idle),
  .stop_end (stop_end),
  .quiet    (quiet),
  .frame_idx(frame_idx)
);

// File: tb/sirq_agent_tb.sv
module sirq_agent_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NI         = 3;
  localparam int BASE       = 1;
  localparam int NF         = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq = '0;
  logic          h_en = 1'b0;
  logic          h_val = 1'b1;
  logic          drv_en, drv_val;
  logic          bus;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign bus = drv_en ? drv_val : (h_en ? h_val : 1'b1);

  sirq_agent #(.NUM_IRQ(NI), .BASE_SLOT(BASE), .NUM_FRAMES(NF)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq),
    .bus_in (bus),
    .drv_en (drv_en),
    .drv_val(drv_val)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one clock: observe agent drive for this clock, host drive set after
  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_n(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      step();
      h_en = 1'b0;
      chk(drv_en == 1'b0, req, "idle drv_en", int'(drv_en), 0);
    end
  endtask

  // Host side of one serial cycle. Ends in the first idle clock after turnaround.
  task automatic host_cycle(input bit agent_start, input int stop_w,
                            input int chg_f, input logic [NI-1:0] chg_v);
    int host_low;
    logic cur;
    bit has;
    host_low = agent_start ? 3 : 4;
    if (agent_start) begin
      step();
      h_en = 1'b0;
      chk(drv_en == 1'b1 && drv_val == 1'b0, "R3", "start drive low",
          int'({drv_en, drv_val}), 2);
    end
    for (int k = 0; k < host_low; k++) begin
      step();
      chk(drv_en == 1'b0, agent_start && k == 0 ? "R3" : "R6", "start low clock",
          int'(drv_en), 0);
      h_en = 1'b1; h_val = 1'b0;
    end
    step();
    chk(drv_en == 1'b0, "R6", "start recovery", int'(drv_en), 0);
    h_en = 1'b1; h_val = 1'b1;
    cur = 1'b0;
    for (int f = 0; f < NF; f++) begin
      has = (f >= BASE) && (f < BASE + NI);
      for (int ph = 0; ph < 3; ph++) begin
        bit exp_en;
        step();
        h_en = 1'b0;
        if (ph == 0) cur = has ? irq[f - BASE] : 1'b0;
        exp_en = has && cur && (ph != 2);
        chk(drv_en == exp_en,
            ph == 0 ? "R6" : (has ? "R7" : "R8"),
            $sformatf("frame %0d phase %0d drv_en", f, ph), int'(drv_en), int'(exp_en));
        if (exp_en)
          chk(drv_val == (ph == 1),
              (chg_f >= 0 && f > chg_f) ? "R11" : "R7",
              $sformatf("frame %0d phase %0d drv_val", f, ph),
              int'(drv_val), int'(ph == 1));
        if (ph == 0 && f == chg_f) irq = chg_v;
      end
    end
    for (int k = 0; k < stop_w; k++) begin
      step();
      chk(drv_en == 1'b0, "R9", "stop low clock", int'(drv_en), 0);
      h_en = 1'b1; h_val = 1'b0;
    end
    step();
    chk(drv_en == 1'b0, "R9", "stop high clock", int'(drv_en), 0);
    h_en = 1'b1; h_val = 1'b1;
    step();
    chk(drv_en == 1'b0, "R10", "turnaround", int'(drv_en), 0);
    h_en = 1'b0;
    step();
    chk(drv_en == 1'b0, "R10", "first idle", int'(drv_en), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    logic [NI-1:0] prev;
    // R1: reset state
    repeat (3) step();
    chk(drv_en == 1'b0, "R1", "drv_en in reset", int'(drv_en), 0);
    rst_n = 1'b1;
    step();
    chk(drv_en == 1'b0, "R1", "drv_en after reset", int'(drv_en), 0);

    // R2: continuous after reset, pending change must not start a cycle
    irq = 3'b101;
    idle_n(8, "R2");
    host_cycle(1'b0, 3, -1, '0);
    irq = 3'b011;
    idle_n(6, "R2");

    // Continuous sweep of all patterns, host-opened cycles
    for (int v = 0; v < 8; v++) begin
      irq = NI'(v);
      idle_n(2, "R2");
      host_cycle(1'b0, 3, -1, '0);
    end

    // Switch to quiet with a width-2 stop; inputs delivered, so no start (R1 mode proof follows)
    host_cycle(1'b0, 2, -1, '0);
    idle_n(5, "R3");
    // R3: change while idle in quiet mode opens a cycle next clock
    irq = 3'b010;
    host_cycle(1'b1, 2, -1, '0);
    idle_n(4, "R3");

    // R4: change before slots within a host cycle, no extra cycle afterwards
    host_cycle(1'b0, 2, 0, 3'b111);
    idle_n(6, "R4");

    // R5/R10: change after slot 1 passed, agent opens a cycle after the stop
    host_cycle(1'b0, 2, 2, 3'b110);
    host_cycle(1'b1, 2, -1, '0);
    idle_n(3, "R5");

    // R9: width 3 -> continuous
    host_cycle(1'b0, 3, -1, '0);
    irq = 3'b000;
    idle_n(6, "R9");
    // R9: width 4 leaves continuous
    host_cycle(1'b0, 4, -1, '0);
    irq = 3'b101;
    idle_n(6, "R9");
    // R9: width 2 -> quiet, pending change starts a cycle
    host_cycle(1'b0, 2, -1, '0);
    irq = 3'b100;
    host_cycle(1'b1, 2, -1, '0);

    // Quiet sweep: agent opens a cycle whenever the pattern differs (R3, R8)
    prev = 3'b100;
    for (int v = 0; v < 8; v++) begin
      idle_n(2, "R3");
      irq = NI'(v);
      host_cycle(NI'(v) != prev, 2, -1, '0);
      prev = NI'(v);
    end
    // R9: width 4 leaves quiet
    host_cycle(1'b0, 4, -1, '0);
    irq = 3'b001;
    host_cycle(1'b1, 3, -1, '0);
    irq = 3'b000;
    idle_n(6, "R9");

    report();
  end

endmodule